// File: doc/BRIEF.md
# Event and Quadrature Counter

An 8-bit counter with a small register set. In its normal mode it counts up on one of two sources. The first source is an internal cycle strobe. The second is a selected edge of an external event pin. When the count wraps from 0xFF to 0x00, a sticky overflow flag is set, and that flag can drive an interrupt output if the interrupt is enabled.

Setting a single mode bit turns the block into an up/down counter fed by two quadrature photo-coupler channels, X1 and X2. In this mode the source, edge and interrupt-enable settings stop having any effect. The counter steps up when an X1 edge comes before the matching X2 edge, and steps down when it comes after.

Software loads the count, reads the count, and sets the configuration through one write port and one combinational read port. All three external inputs pass through a two-stage synchronizer before any edge is detected.

Top module: `evt_quad_counter`

## Requirements
- R1: After reset, address 0 (count), address 1 (control) and address 2 (mode) all read 0x00, and irq is low.
- R2: Control byte layout: bit 2 is the interrupt enable, bit 1 is the source select (1 = event pin), bit 0 is the edge select (1 = falling), and bit 7 is the overflow flag. Control bits 6:3 read as zero. Mode byte layout: bit 7 is the mode enable, and bits 6:0 read as zero. Address 3 reads zero.
- R3: In normal mode with source select 0, the count increases by one on every clock in which cycle_tick is high.
- R4: In normal mode with source select 1, the count increases by one on each selected edge of ev_pin (rising when bit 0 = 0, falling when bit 0 = 1). The new count is visible within four clocks of the pin change. In this setting cycle_tick has no effect.
- R5: In normal mode, a wrap from 0xFF to 0x00 sets control bit 7. The flag stays set until a control write with bit 7 = 0. A control write with bit 7 = 1 never sets the flag. If a wrap and a clear fall in the same cycle, the wrap wins.
- R6: irq is high exactly when the flag is set, the interrupt enable is set, and mode is off.
- R7: In mode-on, each single-channel step of the Gray sequence {X1,X2} = 00→10→11→01→00 increments the count, and each step in the reverse direction decrements it. ev_pin, cycle_tick and the control bits have no effect on the count.
- R8: In mode-on, the count wraps in both directions and never sets the flag, so irq stays low.
- R9: A change of X1 and X2 in the same synchronized sample is ignored.
- R10: A write to the count loads wr_data and takes precedence over any count event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 count, 1 control, 2 mode) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| cycle_tick | input | 1 | Internal cycle strobe |
| ev_pin | input | 1 | External event pin (asynchronous) |
| quad_x1 | input | 1 | Quadrature channel X1 (asynchronous) |
| quad_x2 | input | 1 | Quadrature channel X2 (asynchronous) |
| irq | output | 1 | Overflow interrupt |

## Verification
A wrong synchronizer or edge-history bit shows up as a count that is off by one. This appears within four clocks of a pin change, and it is caught because the bench reads the count after every quadrature step and every event edge. A flag that is set wrongly, or not cleared, is visible immediately on control bit 7 and on irq. A direction error in the decoder makes the random walk drift away from the bench's own tally at the first affected step.

// File: rtl/evt_quad_counter.sv
module evt_quad_counter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       cycle_tick,
  input  logic       ev_pin,
  input  logic       quad_x1,
  input  logic       quad_x2,
  output logic       irq
);
  localparam logic [1:0] A_CNT  = 2'd0;
  localparam logic [1:0] A_CTL  = 2'd1;
  localparam logic [1:0] A_MODE = 2'd2;
  localparam int         TOP    = SYNC_STAGES - 1;

  logic [7:0] cnt;
  logic       ie, src_ext, edge_fall, flag, mouse;
  logic [TOP:0] ev_sr, x1_sr, x2_sr;
  logic       ev_d, x1_d, x2_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_sr <= '0; x1_sr <= '0; x2_sr <= '0;
      ev_d  <= 1'b0; x1_d <= 1'b0; x2_d <= 1'b0;
    end else begin
      ev_sr <= {ev_sr[TOP-1:0], ev_pin};
      x1_sr <= {x1_sr[TOP-1:0], quad_x1};
      x2_sr <= {x2_sr[TOP-1:0], quad_x2};
      ev_d  <= ev_sr[TOP];
      x1_d  <= x1_sr[TOP];
      x2_d  <= x2_sr[TOP];
    end
  end

  logic ev_s, x1_s, x2_s, ev_hit, x1_chg, x2_chg, q_up, q_dn, norm_step;
  logic wr_cnt, wr_ctl, wr_mode, wrap;

  assign ev_s      = ev_sr[TOP];
  assign x1_s      = x1_sr[TOP];
  assign x2_s      = x2_sr[TOP];
  assign ev_hit    = edge_fall ? (ev_d & ~ev_s) : (ev_s & ~ev_d);
  assign x1_chg    = x1_s ^ x1_d;
  assign x2_chg    = x2_s ^ x2_d;
  assign q_up      = (x1_chg & ~x2_chg & (x1_s ^ x2_s)) | (x2_chg & ~x1_chg & ~(x1_s ^ x2_s));
  assign q_dn      = (x1_chg & ~x2_chg & ~(x1_s ^ x2_s)) | (x2_chg & ~x1_chg & (x1_s ^ x2_s));
  assign norm_step = src_ext ? ev_hit : cycle_tick;
  assign wr_cnt    = wr_en && (wr_addr == A_CNT);
  assign wr_ctl    = wr_en && (wr_addr == A_CTL);
  assign wr_mode   = wr_en && (wr_addr == A_MODE);
  assign wrap      = !wr_cnt && !mouse && norm_step && (cnt == 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 8'h00;
    end else if (wr_cnt) begin
      cnt <= wr_data;
    end else if (mouse) begin
      if (q_up)      cnt <= cnt + 8'd1;
      else if (q_dn) cnt <= cnt - 8'd1;
    end else if (norm_step) begin
      cnt <= cnt + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ie, src_ext, edge_fall} <= 3'b000;
      flag  <= 1'b0;
      mouse <= 1'b0;
    end else begin
      if (wr_ctl)  {ie, src_ext, edge_fall} <= wr_data[2:0];
      if (wr_mode) mouse <= wr_data[7];
      flag <= wrap | (flag & ~(wr_ctl & ~wr_data[7]));
    end
  end

  assign irq = flag & ie & ~mouse;

  always_comb begin
    case (rd_addr)
      A_CNT:   rd_data = cnt;
      A_CTL:   rd_data = {flag, 4'b0000, ie, src_ext, edge_fall};
      A_MODE:  rd_data = {mouse, 7'b0000000};
      default: rd_data = 8'h00;
    endcase
  end

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(wr_data)); // R10
  AST_NORMAL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !mouse) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 8'd1)); // R3
  AST_MOUSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && mouse) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 8'd1 || cnt == $past(cnt) - 8'd1)); // R7
  AST_DOUBLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && mouse && x1_chg && x2_chg) |=> $stable(cnt)); // R9
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(cnt) == 8'hFF && !$past(mouse))); // R5
  AST_MOUSE_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mouse && !flag) |=> !flag); // R8
endmodule

// File: tb/test_evt_quad_counter.sv
module test_evt_quad_counter;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, cycle_tick, ev_pin, quad_x1, quad_x2;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  evt_quad_counter i_evt_quad_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cycle_tick(cycle_tick), .ev_pin(ev_pin),
    .quad_x1(quad_x1), .quad_x2(quad_x2), .irq(irq));

  function automatic logic [1:0] gray(input int idx);
    case (idx & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  int idx = 0;
  task automatic quad_step(input bit up);
    idx = up ? idx + 1 : idx + 3;
    {quad_x1, quad_x2} = gray(idx);
    cycles(4);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v, exp_cnt;
    bit exp_flag;
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    cycle_tick = 1'b0; ev_pin = 1'b0; quad_x1 = 1'b0; quad_x2 = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    rd(2'd0, v); check("R1 count", v, 8'h00);
    rd(2'd1, v); check("R1 control", v, 8'h00);
    rd(2'd2, v); check("R1 mode", v, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    wr(2'd1, 8'hFF); rd(2'd1, v); check("R2 control layout", v, 8'h07);
    wr(2'd2, 8'hFF); rd(2'd2, v); check("R2 mode layout", v, 8'h80);
    wr(2'd2, 8'h00); rd(2'd3, v); check("R2 unused address", v, 8'h00);
    wr(2'd1, 8'h00);

    wr(2'd0, 8'h10);
    cycle_tick = 1'b1; cycles(5); cycle_tick = 1'b0;
    rd(2'd0, v); check("R3 internal ticks", v, 8'h15);

    @(negedge clk);
    cycle_tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h55;
    @(negedge clk);
    wr_en = 1'b0; cycle_tick = 1'b0;
    rd(2'd0, v); check("R10 write beats tick", v, 8'h55);

    wr(2'd1, 8'h02); wr(2'd0, 8'h00); cycle_tick = 1'b1;
    ev_pin = 1'b1; cycles(4); rd(2'd0, v); check("R4 rising counted", v, 8'h01);
    ev_pin = 1'b0; cycles(4); rd(2'd0, v); check("R4 falling ignored", v, 8'h01);
    wr(2'd1, 8'h03);
    ev_pin = 1'b1; cycles(4); rd(2'd0, v); check("R4 rising ignored", v, 8'h01);
    ev_pin = 1'b0; cycles(4); rd(2'd0, v); check("R4 falling counted", v, 8'h02);
    cycle_tick = 1'b0;

    wr(2'd1, 8'h00); wr(2'd0, 8'hFE);
    cycle_tick = 1'b1; cycles(2); cycle_tick = 1'b0;
    rd(2'd0, v); check("R5 wrap count", v, 8'h00);
    rd(2'd1, v); check("R5 flag set", v, 8'h80);
    check("R6 masked irq", {7'b0, irq}, 8'h00);
    wr(2'd1, 8'h84); rd(2'd1, v); check("R5 write 1 keeps flag", v, 8'h84);
    check("R6 irq asserted", {7'b0, irq}, 8'h01);
    wr(2'd1, 8'h04); rd(2'd1, v); check("R5 flag cleared", v, 8'h04);
    check("R6 irq dropped", {7'b0, irq}, 8'h00);

    wr(2'd1, 8'h00);
    exp_cnt = 8'($urandom);
    exp_flag = 1'b0;
    wr(2'd0, exp_cnt);
    for (int i = 0; i < 300; i++) begin
      cycle_tick = 1'($urandom);
      @(negedge clk);
      if (cycle_tick) begin
        if (exp_cnt == 8'hFF) exp_flag = 1'b1;
        exp_cnt = exp_cnt + 8'd1;
      end
    end
    cycle_tick = 1'b0;
    rd(2'd0, v); check("R3 random ticks", v, exp_cnt);
    rd(2'd1, v); check("R5 random flag", v, {exp_flag, 7'b0});

    wr(2'd1, 8'h05); wr(2'd2, 8'h80); wr(2'd0, 8'h80);
    cycle_tick = 1'b1;
    for (int i = 0; i < 3; i++) quad_step(1'b1);
    rd(2'd0, v); check("R7 up steps", v, 8'h83);
    for (int i = 0; i < 5; i++) quad_step(1'b0);
    rd(2'd0, v); check("R7 down steps", v, 8'h7E);
    for (int i = 0; i < 4; i++) begin ev_pin = ~ev_pin; cycles(3); end
    rd(2'd0, v); check("R7 tick and pin ignored", v, 8'h7E);
    cycle_tick = 1'b0;

    wr(2'd0, 8'hFF); quad_step(1'b1);
    rd(2'd0, v); check("R8 up wrap", v, 8'h00);
    rd(2'd1, v); check("R8 no flag", v, 8'h05);
    check("R8 irq low", {7'b0, irq}, 8'h00);
    quad_step(1'b0);
    rd(2'd0, v); check("R8 down wrap", v, 8'hFF);

    idx = idx + 2;
    {quad_x1, quad_x2} = gray(idx);
    cycles(4);
    rd(2'd0, v); check("R9 double change ignored", v, 8'hFF);

    exp_cnt = 8'hFF;
    for (int i = 0; i < 60; i++) begin
      bit up;
      up = 1'($urandom);
      quad_step(up);
      exp_cnt = up ? exp_cnt + 8'd1 : exp_cnt - 8'd1;
      rd(2'd0, v); check("R7 random walk", v, exp_cnt);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule